// File: doc/BRIEF.md
# DMA command list walker

A single-channel memory-to-memory copy engine driven by a two-level list in memory. Software writes the command-pointer register with the list-walk mode code and the address of an outer list of 32-bit pointer entries. Each pointer entry names an array of four-word copy descriptors. The walker reads each descriptor and copies the word range it describes. It then moves on within the array, and across arrays, until the outer list ends.

When a walk ends, normally or because of a bad descriptor, a result word is queued in a small result FIFO. The host pops one entry per read of the result register. An interrupt line stays high while results are pending and the interrupt is enabled. All memory traffic uses one valid/ready request port. Read data returns on a separate registered response.

Top module: `cmdlist_walker`

## Requirements
- R1: After reset the status register (host address 2) reads ready bit 0 = 1, pending bit 1 = 0, result count bits 31:29 = 0 and command count bits 28:27 = 0. The interrupt is low and a read of the result register (host address 1) returns 0.
- R2: A write to the command-pointer register (host address 0) whose bits 30:29 equal 1 starts a walk at byte address {bits 28:0, 3'b000}. From the cycle after the write until the result is queued, status bit 0 reads 0 and bits 28:27 read 1.
- R3: A pointer entry names its descriptor array at byte address {bits 28:0, 3'b000}, and its bit 31 marks the last entry. A descriptor is four consecutive words: command, source, destination and byte length. Command bit 31 marks the last descriptor of its array. After that descriptor the walker reads the next pointer entry, or ends the walk if the current entry was marked last.
- R4: A descriptor copies length/4 words. Word i is read from source+4i and written to destination+4i. A length of 0 copies nothing and leaves the destination untouched.
- R5: A walk that completes normally queues the result 0x80000002 (valid bit 31, done bit 1).
- R6: A descriptor whose command bits 1:0 are not 0 ends the walk at once and queues 0x80000008 (valid bit 31, error bit 3). No later descriptor is processed. A command-pointer write whose bits 30:29 are not 1 queues 0x80000008 without any memory access.
- R7: A command-pointer write made while a walk is in progress has no effect.
- R8: The result FIFO holds 4 entries in arrival order. A read of host address 1 returns the oldest entry and pops it. When the FIFO is empty, that read returns 0 (bit 31 clear). Status bit 1 is set when the FIFO is not empty, and bits 31:29 give the entry count.
- R9: When the FIFO is full, a finishing walk holds with status bit 0 low until a pop frees a slot. Its result is then queued after the older ones.
- R10: Config register (host address 3) bit 0 is the interrupt enable and reads back as written. The interrupt is high exactly while the enable is set and the FIFO is not empty.
- R11: A memory request is held stable until accepted. After a read is accepted, no new request is issued until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops result at address 1) |
| host_addr | input | 2 | Register select: 0 command pointer, 1 result, 2 status, 3 config |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Result-pending interrupt |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |

## Verification
The bench builds the block with the default four-entry result FIFO. With that depth, a full FIFO, a stalled fifth walk and the order of mixed done and error entries are reached in a handful of walks. Descriptor lengths are swept from zero to six words against a memory model whose ready signal stalls every third cycle. This exercises copies of every short length under back-pressure.

// File: rtl/cmdlist_walker.sv
module cmdlist_walker #(
  parameter int RES_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        irq,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_we,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam int PW = (RES_DEPTH > 1) ? $clog2(RES_DEPTH) : 1;
  localparam int CW = $clog2(RES_DEPTH + 1);
  localparam logic [1:0] A_PTR = 2'd0, A_RES = 2'd1, A_STAT = 2'd2, A_CFG = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_PTR_REQ, S_PTR_WAIT, S_DSC_REQ, S_DSC_WAIT,
    S_NEXT, S_SRC_REQ, S_SRC_WAIT, S_DST_REQ, S_PUSH
  } state_t;

  state_t      state;
  logic [31:0] ptr_addr, dsc_addr, src, dst, len, copy_word;
  logic [1:0]  idx;
  logic        last_ptr, last_cmd, err, irq_en;
  logic        res_err [RES_DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] res_cnt;
  logic        cmd_idle, fifo_full, push, pop, accepted, start;
  logic        unused_bits;

  assign unused_bits = ^{host_wdata[31], mem_rsp_data[30:29]};

  assign cmd_idle  = (state == S_IDLE);
  assign fifo_full = (res_cnt == CW'(RES_DEPTH));
  assign push      = (state == S_PUSH) && !fifo_full;
  assign pop       = host_rd && (host_addr == A_RES) && (res_cnt != '0);
  assign accepted  = mem_req_valid && mem_req_ready;
  assign start     = host_wr && (host_addr == A_PTR) && cmd_idle;

  assign mem_req_valid = (state == S_PTR_REQ) || (state == S_DSC_REQ) ||
                         (state == S_SRC_REQ) || (state == S_DST_REQ);
  assign mem_req_we    = (state == S_DST_REQ);
  assign mem_req_wdata = copy_word;

  always_comb begin
    case (state)
      S_PTR_REQ: mem_req_addr = ptr_addr;
      S_DSC_REQ: mem_req_addr = dsc_addr + {28'd0, idx, 2'b00};
      S_SRC_REQ: mem_req_addr = src;
      S_DST_REQ: mem_req_addr = dst;
      default:   mem_req_addr = '0;
    endcase
  end

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(RES_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr_addr  <= '0;
      dsc_addr  <= '0;
      src       <= '0;
      dst       <= '0;
      len       <= '0;
      copy_word <= '0;
      idx       <= '0;
      last_ptr  <= 1'b0;
      last_cmd  <= 1'b0;
      err       <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (host_wdata[30:29] == 2'd1) begin
            ptr_addr <= {host_wdata[28:0], 3'b000};
            err      <= 1'b0;
            state    <= S_PTR_REQ;
          end else begin
            err   <= 1'b1;
            state <= S_PUSH;
          end
        end
        S_PTR_REQ: if (accepted) state <= S_PTR_WAIT;
        S_PTR_WAIT: if (mem_rsp_valid) begin
          last_ptr <= mem_rsp_data[31];
          dsc_addr <= {mem_rsp_data[28:0], 3'b000};
          ptr_addr <= ptr_addr + 32'd4;
          idx      <= '0;
          state    <= S_DSC_REQ;
        end
        S_DSC_REQ: if (accepted) state <= S_DSC_WAIT;
        S_DSC_WAIT: if (mem_rsp_valid) begin
          idx   <= idx + 1'b1;
          state <= S_DSC_REQ;
          case (idx)
            2'd0: begin
              last_cmd <= mem_rsp_data[31];
              if (mem_rsp_data[1:0] != 2'd0) begin
                err   <= 1'b1;
                state <= S_PUSH;
              end
            end
            2'd1: src <= mem_rsp_data;
            2'd2: dst <= mem_rsp_data;
            default: begin
              len   <= mem_rsp_data;
              state <= S_NEXT;
            end
          endcase
        end
        S_NEXT: begin
          if (len >= 32'd4) state <= S_SRC_REQ;
          else if (!last_cmd) begin
            dsc_addr <= dsc_addr + 32'd16;
            idx      <= '0;
            state    <= S_DSC_REQ;
          end else if (last_ptr) state <= S_PUSH;
          else state <= S_PTR_REQ;
        end
        S_SRC_REQ: if (accepted) state <= S_SRC_WAIT;
        S_SRC_WAIT: if (mem_rsp_valid) begin
          copy_word <= mem_rsp_data;
          state     <= S_DST_REQ;
        end
        S_DST_REQ: if (accepted) begin
          src   <= src + 32'd4;
          dst   <= dst + 32'd4;
          len   <= len - 32'd4;
          state <= S_NEXT;
        end
        S_PUSH: if (push) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      res_cnt <= '0;
      irq_en  <= 1'b0;
      for (int i = 0; i < RES_DEPTH; i++) res_err[i] <= 1'b0;
    end else begin
      if (push) begin
        res_err[wr_ptr] <= err;
        wr_ptr <= wrap_inc(wr_ptr);
      end
      if (pop) rd_ptr <= wrap_inc(rd_ptr);
      if (push && !pop) res_cnt <= res_cnt + 1'b1;
      else if (pop && !push) res_cnt <= res_cnt - 1'b1;
      if (host_wr && host_addr == A_CFG) irq_en <= host_wdata[0];
    end
  end

  logic [31:0] res_word, stat_word;
  assign res_word  = (res_cnt == '0) ? 32'd0 :
                     {1'b1, 27'd0, res_err[rd_ptr], 1'b0, !res_err[rd_ptr], 1'b0};
  assign stat_word = {3'(res_cnt), 1'b0, !cmd_idle, 25'd0, res_cnt != '0, cmd_idle};

  always_comb begin
    case (host_addr)
      A_RES:   host_rdata = res_word;
      A_STAT:  host_rdata = stat_word;
      A_CFG:   host_rdata = {31'd0, irq_en};
      default: host_rdata = 32'd0;
    endcase
  end

  assign irq = irq_en && (res_cnt != '0);
endmodule

module cmdlist_walker_chk #(
  parameter int DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rd,
  input logic [1:0]    host_addr,
  input logic [31:0]   host_rdata,
  input logic          irq,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [31:0]   mem_req_addr,
  input logic          mem_rsp_valid,
  input logic [CW-1:0] res_cnt,
  input logic          cmd_idle
);
  logic pending;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_we) pending <= 1'b1;
    else if (mem_rsp_valid) pending <= 1'b0;
  end

  // R11
  no_req_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !mem_req_valid);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  // R2
  busy_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmd_idle);

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_cnt <= CW'(DEPTH));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 2'd1 && res_cnt == '0 |-> host_rdata == 32'd0);

  // R10
  irq_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && host_addr == 2'd1 |-> host_rdata[31]);
endmodule

bind cmdlist_walker cmdlist_walker_chk #(.DEPTH(RES_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_addr(host_addr),
  .host_rdata(host_rdata), .irq(irq), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .res_cnt(res_cnt), .cmd_idle(cmd_idle)
);

// File: tb/test_cmdlist_walker.sv
module test_cmdlist_walker;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [1:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic irq, mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data;
  logic mem_rsp_valid;

  always #5 clk = ~clk;

  cmdlist_walker i_cmdlist_walker (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  logic [31:0] mem [256];
  int cyc = 0, nreq = 0, tests = 0, fails = 0;
  logic done_flag = 0;

  assign mem_req_ready = (cyc % 3) != 2;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      nreq <= nreq + 1;
      if (mem_req_we) mem[mem_req_addr[9:2]] <= mem_req_wdata;
      else begin
        mem_rsp_data  <= mem[mem_req_addr[9:2]];
        mem_rsp_valid <= 1'b1;
      end
    end
  end

  function automatic logic [31:0] srcv(int i); return 32'h5A00_0000 | i; endfunction
  function automatic logic [31:0] sent(int i); return 32'hDEAD_0000 | i; endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = (i >= 192) ? sent(i) : srcv(i);
  endtask

  task automatic desc(input int a, input logic [31:0] c, s, d, l);
    mem[a/4] = c; mem[a/4+1] = s; mem[a/4+2] = d; mem[a/4+3] = l;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk); host_addr = 2'd1; host_rd = 1; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 5000; k++) begin
      peek(2'd2, s);
      if (s[0]) break;
    end
  endtask

  task automatic start(input int list);
    wr(2'd0, 32'h2000_0000 | (list >> 3));
  endtask

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    if (!done_flag) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s;
    int n0;
    bit ok;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    peek(2'd2, s);
    check(s == 32'h0000_0001, "R1 status", s, 32'h1);
    check(irq == 0, "R1 irq", {31'd0, irq}, 0);
    peek(2'd1, d);
    check(d == 0, "R1 result empty", d, 0);

    // R2 R3 R4 R5 two-level walk
    mem[64] = 32'h0000_0000 | (32'h180 >> 3);
    mem[65] = 32'h8000_0000 | (32'h1C0 >> 3);
    desc(32'h180, 32'h0, 32'h200, 32'h300, 8);
    desc(32'h190, 32'h8000_0000, 32'h210, 32'h310, 12);
    desc(32'h1C0, 32'h0, 32'h230, 32'h330, 0);
    desc(32'h1D0, 32'h8000_0000, 32'h240, 32'h340, 4);
    start(32'h100);
    peek(2'd2, s);
    check(s[0] == 0 && s[28:27] == 2'd1, "R2 busy status", s, 32'h0800_0000);
    wait_idle();
    ok = 1;
    for (int i = 0; i < 2; i++) ok &= mem[192+i] == srcv(128+i);
    for (int i = 0; i < 3; i++) ok &= mem[196+i] == srcv(132+i);
    ok &= mem[199] == sent(199);
    check(ok, "R3 two-level copy", mem[196], srcv(132));
    check(mem[204] == sent(204), "R4 zero length", mem[204], sent(204));
    check(mem[208] == srcv(144) && mem[209] == sent(209), "R4 one word", mem[209], sent(209));
    pop(d);
    check(d == 32'h8000_0002, "R5 done result", d, 32'h8000_0002);

    // R4 length sweep
    for (int n = 0; n <= 6; n++) begin
      clear_mem();
      mem[64] = 32'h8000_0000 | (32'h180 >> 3);
      desc(32'h180, 32'h8000_0000, 32'h200, 32'h300, 4*n);
      start(32'h100);
      wait_idle();
      ok = 1;
      for (int i = 0; i < 8; i++) ok &= mem[192+i] == ((i < n) ? srcv(128+i) : sent(192+i));
      check(ok, $sformatf("R4 sweep n=%0d", n), mem[192+n], sent(192+n));
      pop(d);
      check(d == 32'h8000_0002, "R5 sweep result", d, 32'h8000_0002);
    end

    // R6 bad descriptor mode
    clear_mem();
    mem[64] = 32'h0000_0000 | (32'h180 >> 3);
    mem[65] = 32'h8000_0000 | (32'h1C0 >> 3);
    desc(32'h180, 32'h0, 32'h200, 32'h300, 4);
    desc(32'h190, 32'h8000_0002, 32'h210, 32'h310, 4);
    desc(32'h1C0, 32'h8000_0000, 32'h220, 32'h320, 4);
    start(32'h100);
    wait_idle();
    check(mem[192] == srcv(128) && mem[196] == sent(196) && mem[200] == sent(200),
          "R6 stop after bad mode", mem[200], sent(200));
    pop(d);
    check(d == 32'h8000_0008, "R6 error result", d, 32'h8000_0008);
    n0 = nreq;
    wr(2'd0, 32'h0000_0020);
    wait_idle();
    check(nreq == n0, "R6 bad pointer mode no access", nreq, n0);
    pop(d);
    check(d == 32'h8000_0008, "R6 bad pointer mode result", d, 32'h8000_0008);

    // R7 write while busy
    clear_mem();
    mem[64] = 32'h8000_0000 | (32'h180 >> 3);
    desc(32'h180, 32'h8000_0000, 32'h200, 32'h300, 24*4);
    mem[72] = 32'h8000_0000 | (32'h1C0 >> 3);
    desc(32'h1C0, 32'h8000_0000, 32'h200, 32'h380, 4);
    start(32'h100);
    repeat (5) @(negedge clk);
    start(32'h120);
    wait_idle();
    peek(2'd2, s);
    check(mem[224] == sent(224) && s[31:29] == 3'd1, "R7 ignored write", s, 32'h2000_0002);
    pop(d);

    // R10 interrupt
    mem[64] = 32'h8000_0000 | (32'h180 >> 3);
    desc(32'h180, 32'h8000_0000, 32'h200, 32'h300, 0);
    start(32'h100);
    wait_idle();
    check(irq == 0, "R10 irq disabled", {31'd0, irq}, 0);
    wr(2'd3, 1);
    peek(2'd3, d);
    check(d == 1 && irq == 1, "R10 irq enabled", {d[30:0], irq}, 3);
    pop(d);
    @(negedge clk);
    check(irq == 0, "R10 irq after drain", {31'd0, irq}, 0);
    peek(2'd1, d);
    check(d == 0, "R8 empty read", d, 0);

    // R8 R9 fill FIFO
    start(32'h100); wait_idle();
    wr(2'd0, 0);    wait_idle();
    start(32'h100); wait_idle();
    start(32'h100); wait_idle();
    peek(2'd2, s);
    check(s[31:29] == 3'd4 && s[1] == 1, "R8 full count", s, 32'h8000_0003);
    start(32'h100);
    repeat (60) @(negedge clk);
    peek(2'd2, s);
    check(s[0] == 0, "R9 stalled when full", s, 0);
    pop(d);
    check(d == 32'h8000_0002, "R8 order 0", d, 32'h8000_0002);
    wait_idle();
    peek(2'd2, s);
    check(s[31:29] == 3'd4, "R9 queued after pop", s, 32'h8000_0003);
    pop(d);
    check(d == 32'h8000_0008, "R8 order 1", d, 32'h8000_0008);
    for (int i = 2; i < 5; i++) begin
      pop(d);
      check(d == 32'h8000_0002, $sformatf("R8 order %0d", i), d, 32'h8000_0002);
    end
    peek(2'd1, d);
    check(d == 0, "R8 drained", d, 0);

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule